// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces the repeated-start condition for an I2C bus master. A host sets a request bit in a small control register. The block then drives the open-drain enables for SCL and SDA through a fixed series of phases. A reloadable down-counter times each phase. The real line levels are read back through a synchroniser, and each phase moves on only when those levels match what the bus should show. A slave that holds SCL low stretches the sequence, and the block waits for it.

While the sequence runs, the block locks out new host requests and blocks writes to the transmit buffer. A blocked buffer write raises a write-collision flag. A start pattern seen on the lines sets a start-detected flag. Normal completion raises an interrupt flag and leaves SDA driven low, ready for the first address bit. If another master interferes, the block raises a bus-collision flag and releases the bus. The host clears all flags with one pulse.

Top module: `i2c_rstart_seq`

## Requirements
- R1: Writing the control register with bit 1 (the request bit) at 1 starts the sequence only when the block is idle and `other_busy` is low. In that case `busy` rises on the next cycle with `scl_oe`=1 and `sda_oe`=0. With `other_busy` high the request bit is stored as 0 and nothing starts.
- R2: SCL stays pulled low until the synchronised SCL reads low. Then SDA is released for one baud period with SCL still pulled. At the end of that period, SCL is released only if the synchronised SDA reads high. Otherwise the same phase runs again for another baud period.
- R3: After SCL is released, the block waits for as long as the synchronised SCL stays low (clock stretching). It then times one baud period with both lines released, and after that one baud period with SDA pulled low and SCL released.
- R4: When the SDA-low period ends, `busy` falls, request bit 1 reads 0, `irq` sets, and `sda_oe` stays 1. It stays 1 until `clr_flags` is pulsed or a new request is accepted.
- R5: `start_det` sets when the synchronised SDA goes from 1 to 0 while the synchronised SCL is 1.
- R6: A transmit-buffer write while `busy` is high sets `wcol` and leaves `tx_data` unchanged. A write while idle loads `tx_data`.
- R7: Any control-register write while `busy` is high is ignored, so `ctl_rdata` keeps its value.
- R8: A bus collision is flagged in two cases: the synchronised SCL reads high while the synchronised SDA reads low as the block waits for SCL to rise, or the synchronised SCL reads low during the both-high period. On a collision, both enables drop, request bit 1 clears, `bcol` sets, `irq` stays unchanged, and the block returns to idle.
- R9: `clr_flags` clears `irq`, `wcol`, `bcol` and `start_det`. If a flag is set in the same cycle, the set wins.
- R10: Each baud period lasts `reload`+1 clock cycles. The line inputs pass through a two-flop synchroniser, reset to 1, before any decision uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data; bit 1 is the repeated-start request |
| ctl_rdata | output | 5 | Control register contents |
| other_busy | input | 1 | Another bus event is in progress |
| reload | input | 7 | Baud counter reload value |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | 8 | Transmit buffer write data |
| tx_data | output | 8 | Transmit buffer contents |
| clr_flags | input | 1 | Clears the flags and the held SDA |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Sequence in progress |
| start_det | output | 1 | Start pattern seen on the lines |
| irq | output | 1 | Sequence completed |
| bcol | output | 1 | Bus collision |
| wcol | output | 1 | Write collision on the transmit buffer |

## Verification
Two things can happen in the same cycle. The final baud timeout that raises `irq` can coincide with a host `clr_flags` pulse. The same timeout cycle, while `busy` is still high, can also coincide with a transmit-buffer write. The bench holds `clr_flags` and `tx_wr` high across the whole SDA-low phase, so one of those cycles lands on the completion edge. A behavioural model then judges, on every clock, that `irq` reads 1 for one cycle before it clears, that `wcol` sets, and that `tx_data` stays the same. Clock stretching and both collision cases are provoked by an open-drain slave model in the bench that pulls the lines at chosen phases.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
   typedef enum logic [2:0] {
      RS_IDLE,
      RS_PULL_SCL,
      RS_SDA_REL,
      RS_SCL_REL,
      RS_BOTH_HI,
      RS_SDA_DRV
   } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0][WIDTH-1:0] stg;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rs_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[LAST];
endmodule

// File: rtl/i2c_rs_brg.sv
module i2c_rs_brg #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] reload,
   output logic         tick
);
   logic [W-1:0] cnt;
   logic         run;

   if (W < 1) begin : g_bad_width
      $error("i2c_rs_brg width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= reload;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign tick = run && (cnt == '0);
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
   import i2c_rs_pkg::*;
#(
   parameter int RLD_W       = 7,
   parameter int CTL_W       = 5,
   parameter int RS_BIT      = 1,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   input  logic              other_busy,
   input  logic [RLD_W-1:0]  reload,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic [DATA_W-1:0] tx_data,
   input  logic              clr_flags,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              busy,
   output logic              start_det,
   output logic              irq,
   output logic              bcol,
   output logic              wcol
);
   localparam logic [CTL_W-1:0] RS_MASK = CTL_W'(1) << RS_BIT;

   if (RS_BIT >= CTL_W) begin : g_bad_rsbit
      $error("request bit outside control register");
   end

   rs_state_e   st, st_n;
   logic [1:0]  sync_q;
   logic        s_scl, s_sda, prev_sda;
   logic        brg_load, brg_tick;
   logic        accept, done, coll, sda_hold;
   logic [CTL_W-1:0] ctl_q;

   i2c_rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(sync_q)
   );
   assign s_scl = sync_q[1];
   assign s_sda = sync_q[0];

   i2c_rs_brg #(.W(RLD_W)) u_brg (
      .clk(clk), .rst_n(rst_n), .load(brg_load), .reload(reload), .tick(brg_tick)
   );

   assign busy   = (st != RS_IDLE);
   assign accept = !busy && ctl_wr && ctl_wdata[RS_BIT] && !other_busy;

   always_comb begin
      st_n     = st;
      brg_load = 1'b0;
      done     = 1'b0;
      coll     = 1'b0;
      unique case (st)
         RS_IDLE:     if (accept) st_n = RS_PULL_SCL;
         RS_PULL_SCL: if (!s_scl) begin
                         brg_load = 1'b1;
                         st_n     = RS_SDA_REL;
                      end
         RS_SDA_REL:  if (brg_tick) begin
                         if (s_sda) st_n = RS_SCL_REL;
                         else       brg_load = 1'b1;
                      end
         RS_SCL_REL:  if (s_scl) begin
                         if (!s_sda) coll = 1'b1;
                         else begin
                            brg_load = 1'b1;
                            st_n     = RS_BOTH_HI;
                         end
                      end
         RS_BOTH_HI:  if (!s_scl) coll = 1'b1;
                      else if (brg_tick) begin
                         brg_load = 1'b1;
                         st_n     = RS_SDA_DRV;
                      end
         RS_SDA_DRV:  if (brg_tick) done = 1'b1;
         default:     st_n = RS_IDLE;
      endcase
      if (done || coll) st_n = RS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RS_IDLE;
         ctl_q     <= '0;
         tx_data   <= '0;
         prev_sda  <= 1'b1;
         sda_hold  <= 1'b0;
         irq       <= 1'b0;
         bcol      <= 1'b0;
         wcol      <= 1'b0;
         start_det <= 1'b0;
      end else begin
         st       <= st_n;
         prev_sda <= s_sda;
         if (!busy && ctl_wr) begin
            ctl_q         <= ctl_wdata;
            ctl_q[RS_BIT] <= ctl_wdata[RS_BIT] && !other_busy;
         end
         if (done || coll) ctl_q[RS_BIT] <= 1'b0;
         if (tx_wr && !busy) tx_data <= tx_wdata;
         if (done)                      sda_hold <= 1'b1;
         else if (clr_flags || accept)  sda_hold <= 1'b0;
         if (done)           irq <= 1'b1;
         else if (clr_flags) irq <= 1'b0;
         if (coll)           bcol <= 1'b1;
         else if (clr_flags) bcol <= 1'b0;
         if (tx_wr && busy)  wcol <= 1'b1;
         else if (clr_flags) wcol <= 1'b0;
         if (prev_sda && !s_sda && s_scl) start_det <= 1'b1;
         else if (clr_flags)              start_det <= 1'b0;
      end
   end

   assign scl_oe    = (st == RS_PULL_SCL) || (st == RS_SDA_REL);
   assign sda_oe    = (st == RS_SDA_DRV) || sda_hold;
   assign ctl_rdata = ctl_q;

   p_req_pulls_scl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (scl_oe && !sda_oe));

   p_ctl_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_wr) |=> ((ctl_rdata | RS_MASK) == ($past(ctl_rdata) | RS_MASK)));

   p_tx_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_wr) |=> (wcol && (tx_data == $past(tx_data))));

   p_done_holds_sda_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (sda_oe && !busy));

   p_req_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !ctl_rdata[RS_BIT]);

   p_coll_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bcol) |-> (!scl_oe && !sda_oe && !busy && !$rose(irq)));
endmodule

// File: tb/sim_i2c_rstart_seq.sv
module sim_i2c_rstart_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic [4:0] ctl_rdata;
   logic       other_busy = 1'b0;
   logic [6:0] reload = 7'd3;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic [7:0] tx_data;
   logic       clr_flags = 1'b0;
   logic       scl_oe, sda_oe, busy, start_det, irq, bcol, wcol;
   logic       slv_scl = 1'b0, slv_sda = 1'b0;
   logic       scl_in, sda_in;

   int n_cmp = 0, n_bad = 0;
   bit ended = 0;

   always #5 clk = ~clk;

   assign scl_in = !(scl_oe || slv_scl);
   assign sda_in = !(sda_oe || slv_sda);

   i2c_rstart_seq u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .other_busy(other_busy), .reload(reload),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_data(tx_data),
      .clr_flags(clr_flags), .scl_in(scl_in), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .start_det(start_det),
      .irq(irq), .bcol(bcol), .wcol(wcol)
   );

   // behavioural reference: phase 0 idle,1 pull scl,2 sda released,3 wait scl,4 both high,5 sda low
   int         m_ph = 0, m_cnt = 0;
   bit         m_run = 0;
   bit         m_scl1 = 1, m_scl2 = 1, m_sda1 = 1, m_sda2 = 1, m_prev = 1;
   logic [4:0] m_ctl = '0;
   logic [7:0] m_tx = '0;
   bit         m_irq = 0, m_bcol = 0, m_wcol = 0, m_sdet = 0, m_hold = 0;
   bit         m_scl_oe, m_sda_oe;
   string      scen = "R1";

   always_comb begin
      m_scl_oe = (m_ph == 1) || (m_ph == 2);
      m_sda_oe = (m_ph == 5) || m_hold;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_run = 0;
         m_scl1 = 1; m_scl2 = 1; m_sda1 = 1; m_sda2 = 1; m_prev = 1;
         m_ctl = '0; m_tx = '0; m_hold = 0;
         m_irq = 0; m_bcol = 0; m_wcol = 0; m_sdet = 0;
      end else begin
         bit ln_scl, ln_sda, tk, ld, dn, cl, acc;
         int nph;
         ln_scl = !(m_scl_oe || slv_scl);
         ln_sda = !(m_sda_oe || slv_sda);
         tk  = m_run && (m_cnt == 0);
         acc = (m_ph == 0) && ctl_wr && ctl_wdata[1] && !other_busy;
         ld = 0; dn = 0; cl = 0; nph = m_ph;
         if (m_ph == 0 && acc) nph = 1;
         else if (m_ph == 1 && !m_scl2) begin ld = 1; nph = 2; end
         else if (m_ph == 2 && tk) begin
            if (m_sda2) nph = 3; else ld = 1;
         end else if (m_ph == 3 && m_scl2) begin
            if (!m_sda2) cl = 1; else begin ld = 1; nph = 4; end
         end else if (m_ph == 4) begin
            if (!m_scl2) cl = 1; else if (tk) begin ld = 1; nph = 5; end
         end else if (m_ph == 5 && tk) dn = 1;
         if (dn || cl) nph = 0;
         if (m_ph == 0 && ctl_wr) begin
            m_ctl = ctl_wdata;
            m_ctl[1] = ctl_wdata[1] && !other_busy;
         end
         if (dn || cl) m_ctl[1] = 0;
         if (tx_wr && m_ph == 0) m_tx = tx_wdata;
         if (dn) m_hold = 1; else if (clr_flags || acc) m_hold = 0;
         if (dn) m_irq = 1; else if (clr_flags) m_irq = 0;
         if (cl) m_bcol = 1; else if (clr_flags) m_bcol = 0;
         if (tx_wr && m_ph != 0) m_wcol = 1; else if (clr_flags) m_wcol = 0;
         if (m_prev && !m_sda2 && m_scl2) m_sdet = 1; else if (clr_flags) m_sdet = 0;
         if (ld) begin m_cnt = int'(reload); m_run = 1; end
         else if (m_run) begin
            if (m_cnt == 0) m_run = 0; else m_cnt = m_cnt - 1;
         end
         m_prev = m_sda2;
         m_scl2 = m_scl1; m_scl1 = ln_scl;
         m_sda2 = m_sda1; m_sda1 = ln_sda;
         m_ph = nph;
      end
   end

   task automatic chk(input string req, input string name, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s/%s %s: actual %0d expected %0d at %0t", req, scen, name, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         chk("R2", "scl_oe", scl_oe, m_scl_oe);
         chk("R3", "sda_oe", sda_oe, m_sda_oe);
         chk("R1", "busy", busy, m_ph != 0);
         chk("R4", "irq", irq, m_irq);
         chk("R8", "bcol", bcol, m_bcol);
         chk("R6", "wcol", wcol, m_wcol);
         chk("R5", "start_det", start_det, m_sdet);
         chk("R7", "ctl_rdata", ctl_rdata, m_ctl);
         chk("R6", "tx_data", tx_data, m_tx);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl_write(input logic [4:0] v);
      @(negedge clk); ctl_wr = 1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 0;
   endtask

   task automatic tx_write(input logic [7:0] v);
      @(negedge clk); tx_wr = 1; tx_wdata = v;
      @(negedge clk); tx_wr = 0;
   endtask

   task automatic clear_all();
      @(negedge clk); clr_flags = 1;
      @(negedge clk); clr_flags = 0;
   endtask

   task automatic wait_idle(output int drv_cycles);
      drv_cycles = 0;
      for (int i = 0; i < 2000 && busy; i++) begin
         @(negedge clk);
         if (busy && sda_oe) drv_cycles++;
      end
   endtask

   task automatic wait_scl_rel();
      for (int i = 0; i < 2000 && !(busy && !scl_oe); i++) @(negedge clk);
   endtask

   task automatic wait_sda_drv();
      for (int i = 0; i < 2000 && !(busy && sda_oe); i++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int dc;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      scen = "R1";
      chk("R1", "reset busy", busy, 0);
      chk("R9", "reset flags", {irq, bcol, wcol, start_det}, 0);

      // plain sequence, reload 3
      scen = "R10"; reload = 7'd3;
      ctl_write(5'b00010);
      wait_idle(dc);
      chk("R10", "sda low phase length", dc, 4);
      chk("R4", "irq after done", irq, 1);
      chk("R5", "start seen", start_det, 1);
      cyc(2);
      scen = "R9"; clear_all(); cyc(2);
      chk("R9", "flags cleared", {irq, start_det, sda_oe}, 0);

      // request while another event runs
      scen = "R1"; other_busy = 1;
      ctl_write(5'b10110); cyc(4);
      chk("R1", "no start while other busy", busy, 0);
      other_busy = 0;

      // writes during the sequence
      scen = "R6"; tx_write(8'hA5);
      reload = 7'd5;
      ctl_write(5'b00010); cyc(3);
      tx_write(8'h5A);
      ctl_write(5'b11111);
      wait_idle(dc);
      chk("R6", "tx kept", tx_data, 8'hA5);
      chk("R7", "ctl ignored", ctl_rdata, 5'b00000);
      clear_all();

      // clock stretching
      scen = "R3"; reload = 7'd4;
      ctl_write(5'b00010);
      wait_scl_rel(); slv_scl = 1;
      cyc(20);
      chk("R3", "waits on stretch", busy, 1);
      slv_scl = 0;
      wait_idle(dc);
      chk("R3", "done after stretch", irq, 1);
      clear_all();

      // SDA held low at the end of the released phase
      scen = "R2"; reload = 7'd2;
      ctl_write(5'b00010); slv_sda = 1;
      cyc(20);
      chk("R2", "scl kept low", scl_oe, 1);
      slv_sda = 0;
      wait_idle(dc);
      chk("R2", "completes after retry", irq, 1);
      clear_all();

      // collision: SCL rises while SDA low
      scen = "R8"; reload = 7'd7;
      ctl_write(5'b00010);
      wait_scl_rel(); slv_scl = 1; slv_sda = 1;
      cyc(5); slv_scl = 0; cyc(6);
      chk("R8", "collision sda low", bcol, 1);
      chk("R8", "no irq on collision", irq, 0);
      slv_sda = 0; cyc(3); clear_all();

      // collision: SCL pulled low during both-high period
      ctl_write(5'b00010);
      wait_scl_rel(); cyc(6); slv_scl = 1; cyc(6);
      chk("R8", "collision scl low", {bcol, busy}, 2'b10);
      slv_scl = 0; cyc(3); clear_all();

      // same-cycle: completion with clear and buffer write
      scen = "R9"; reload = 7'd2;
      ctl_write(5'b00010);
      wait_sda_drv();
      clr_flags = 1; tx_wr = 1; tx_wdata = 8'h3C;
      cyc(6);
      clr_flags = 0; tx_wr = 0;
      cyc(3);
      chk("R9", "irq cleared after overlap", irq, 0);

      // zero reload
      scen = "R10"; reload = 7'd0; clear_all();
      ctl_write(5'b00010);
      wait_idle(dc);
      chk("R10", "one-cycle period", dc, 1);
      cyc(4);

      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule